// File: doc/BRIEF.md
# I2C Digital Potentiometer Wiper Controller

This block is the serial front end of a 256-step digitally controlled resistor. A bus master on an I2C two-wire link sets an 8-bit wiper register whose value is brought out as a tap-select code for the resistor ladder (00h is the low end, FFh the high end). A control register at address 02h decides how writes and reads at address 00h are handled. A software model of a non-volatile cell, the initial-value register, is kept inside the block. It survives `rst_ni` and is copied into the wiper register on the first clock after every reset.

When the control register is zero, a write to address 00h followed by STOP starts a timed commit. The commit copies the wiper value into the initial-value register after a programmable time. While that timer runs, the block does not acknowledge its device address, so a master can poll until the commit has finished. A write-protect input, sampled at START, lets writes complete on the bus with every byte acknowledged but prevents any register from changing.

Top module: `i2c_wiper_ctrl`

## Requirements
- R1: `tap_o` always shows the wiper register. On the first clock after `rst_ni` is released, the wiper register loads the initial-value register, whose power-up content is `NV_INIT` and which is not cleared by `rst_ni`.
- R2: A write is START, identification byte `{DEV_ADDR, 0}` (R/W in bit 0, 0 = write), address byte, data byte, STOP. The slave acknowledges each byte by pulling SDA low in the 9th clock. Address 00h loads the wiper and address 02h loads the control register. Any other address is acknowledged but changes nothing.
- R3: A read is START, `{DEV_ADDR,0}`, address byte, repeated START, `{DEV_ADDR,1}`, and then one data byte sent MSB first. At address 00h the data is the initial-value register when the control register is 00h, and the wiper register otherwise. Address 02h returns the control register, and any other address returns 00h.
- R4: If a write to 00h happens while the control register is 00h and write-protect is low, the following STOP starts a commit. The initial-value register takes the wiper value after `NV_CYCLES = (CLK_HZ/1_000_000)*NV_WRITE_US` clocks, and at no other time.
- R5: While a commit runs, the identification byte is not acknowledged and the wiper does not change. Once the commit ends, the identification byte is acknowledged again.
- R6: `wp_i` is sampled at START. When it is high, all bytes of a write are still acknowledged, but no register changes and no commit starts.
- R7: An identification byte whose upper seven bits differ from `DEV_ADDR` is not acknowledged. SDA is then left released for every following byte until the next START.
- R8: A write to 00h while the control register is nonzero updates the wiper without starting a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| wp_i | input | 1 | Write protect, high blocks register changes |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain drive) |
| tap_o | output | 8 | Tap select code for the resistor ladder |

## Verification
The bench builds the block with `CLK_HZ = 1_000_000` and `NV_WRITE_US = 300`, so a commit lasts 300 clocks instead of millions. With that setting, a NACK on an acknowledge poll issued right after the commit and an ACK a few hundred clocks later can both be observed in a short run. `NV_INIT = 5Ah` is chosen to differ from every value the bench writes. This lets a read of the non-volatile copy be told apart from a read of the wiper, and lets the value recalled after reset be traced to the committed byte.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ID, ST_REG, ST_WDATA, ST_RDATA, ST_SKIP
  } bus_st_e;

  localparam logic [7:0] REG_WIPER = 8'h00;
  localparam logic [7:0] REG_CTRL  = 8'h02;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic [2:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= 3'b111;
      else         pipe_q <= {pipe_q[1:0], raw_i[g]};
    end
    assign lvl_o[g]  = pipe_q[1];
    assign rise_o[g] = pipe_q[1] & ~pipe_q[2];
    assign fall_o[g] = ~pipe_q[1] & pipe_q[2];
  end
endmodule

// File: rtl/nv_timer.sv
module nv_timer #(
  parameter int unsigned CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned W = $clog2(CYCLES + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (start_i)      cnt_q <= W'(CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == W'(1)) && !start_i;

  assert_count_down_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !start_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/i2c_wiper_ctrl.sv
module i2c_wiper_ctrl
  import wiper_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h2C,
  parameter logic [7:0]  NV_INIT     = 8'h80,
  parameter int unsigned CLK_HZ      = 125_000_000,
  parameter int unsigned NV_WRITE_US = 20_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       wp_i,
  output logic       sda_oe_o,
  output logic [7:0] tap_o
);
  localparam int unsigned NV_RAW    = (CLK_HZ / 1_000_000) * NV_WRITE_US;
  localparam int unsigned NV_CYCLES = (NV_RAW == 0) ? 1 : NV_RAW;

  logic [1:0] lvl, rise, fall;
  i2c_line_sync #(.N(2)) u_sync (
    .clk_i, .rst_ni, .raw_i({sda_i, scl_i}),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );
  logic sda_lvl, scl_lvl, scl_rise, scl_fall, start_det, stop_det;
  assign scl_lvl   = lvl[0];
  assign sda_lvl   = lvl[1];
  assign scl_rise  = rise[0];
  assign scl_fall  = fall[0];
  assign start_det = scl_lvl & fall[1];
  assign stop_det  = scl_lvl & rise[1];

  bus_st_e    st_q;
  logic [3:0] cnt_q;
  logic [7:0] sh_q, tx_q, reg_addr_q, wiper_q, ctrl_q, rd_val;
  logic       in_ack_q, oe_q, wp_q, commit_q, recall_q;
  logic [7:0] nv_q = NV_INIT;   // emulated non-volatile cell, survives rst_ni
  logic       nv_start, nv_busy, nv_done;

  assign nv_start = stop_det & commit_q;

  nv_timer #(.CYCLES(NV_CYCLES)) u_nv_timer (
    .clk_i, .rst_ni, .start_i(nv_start), .busy_o(nv_busy), .done_o(nv_done)
  );

  always_ff @(posedge clk_i) begin
    if (nv_done) nv_q <= wiper_q;
  end

  always_comb begin
    case (reg_addr_q)
      REG_WIPER: rd_val = (ctrl_q == '0) ? nv_q : wiper_q;
      REG_CTRL:  rd_val = ctrl_q;
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0; tx_q <= '0;
      in_ack_q <= 1'b0; oe_q <= 1'b0; reg_addr_q <= '0;
      wiper_q <= '0; ctrl_q <= '0; wp_q <= 1'b0;
      commit_q <= 1'b0; recall_q <= 1'b1;
    end else begin
      if (recall_q) begin
        wiper_q  <= nv_q;
        recall_q <= 1'b0;
      end
      if (start_det) begin
        st_q <= ST_ID; cnt_q <= '0; in_ack_q <= 1'b0; oe_q <= 1'b0;
        wp_q <= wp_i; commit_q <= 1'b0;
      end else if (stop_det) begin
        st_q <= ST_IDLE; cnt_q <= '0; in_ack_q <= 1'b0; oe_q <= 1'b0;
        commit_q <= 1'b0;
      end else if (st_q != ST_IDLE) begin
        if (scl_rise && !in_ack_q && st_q != ST_SKIP) begin
          sh_q  <= {sh_q[6:0], sda_lvl};
          cnt_q <= cnt_q + 1'b1;
        end
        if (scl_fall) begin
          if (in_ack_q) begin
            in_ack_q <= 1'b0;
            oe_q     <= (st_q == ST_RDATA) ? ~tx_q[7] : 1'b0;
          end else if (st_q == ST_RDATA) begin
            if (cnt_q == 4'd8) begin
              oe_q <= 1'b0;
              st_q <= ST_SKIP;
            end else if (cnt_q != '0) begin
              tx_q <= {tx_q[6:0], 1'b0};
              oe_q <= ~tx_q[6];
            end
          end else if (cnt_q == 4'd8 && st_q != ST_SKIP) begin
            cnt_q <= '0;
            case (st_q)
              ST_ID: begin
                if (sh_q[7:1] == DEV_ADDR && !nv_busy) begin
                  oe_q <= 1'b1; in_ack_q <= 1'b1;
                  st_q <= sh_q[0] ? ST_RDATA : ST_REG;
                  tx_q <= rd_val;
                end else begin
                  st_q <= ST_SKIP;
                end
              end
              ST_REG: begin
                reg_addr_q <= sh_q;
                oe_q <= 1'b1; in_ack_q <= 1'b1;
                st_q <= ST_WDATA;
              end
              ST_WDATA: begin
                oe_q <= 1'b1; in_ack_q <= 1'b1;
                st_q <= ST_SKIP;
                if (!wp_q) begin
                  if (reg_addr_q == REG_WIPER) begin
                    wiper_q  <= sh_q;
                    commit_q <= (ctrl_q == '0);
                  end else if (reg_addr_q == REG_CTRL) begin
                    ctrl_q <= sh_q;
                  end
                end
              end
              default: st_q <= ST_SKIP;
            endcase
          end
        end
      end
    end
  end

  assign sda_oe_o = oe_q;
  assign tap_o    = wiper_q;

  assert_recall_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_q |=> (tap_o == $past(nv_q)));
  assert_nv_on_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(nv_q) |-> $past(nv_done));
  assert_wiper_hold_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv_busy |=> $stable(wiper_q));
  assert_wp_block_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_q |=> ($stable(wiper_q) && $stable(ctrl_q)));
  assert_released_skip_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SKIP && !in_ack_q) |-> !sda_oe_o);
endmodule

// File: tb/i2c_wiper_ctrl_bench.sv
module i2c_wiper_ctrl_bench;
  localparam logic [6:0] DEV = 7'h2C;
  localparam logic [7:0] NVI = 8'h5A;
  localparam int HP = 8;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_drv = 1'b1, wp = 1'b0;
  logic sda_oe;
  logic [7:0] tap;
  wire sda_line = sda_drv & ~sda_oe;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  i2c_wiper_ctrl #(.DEV_ADDR(DEV), .NV_INIT(NVI), .CLK_HZ(1_000_000), .NV_WRITE_US(300))
    u_i2c_wiper_ctrl (.clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
                      .wp_i(wp), .sda_oe_o(sda_oe), .tap_o(tap));

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic i2c_start(); sda_drv = 1'b0; wt(HP); scl = 1'b0; wt(2); endtask
  task automatic i2c_rstart();
    sda_drv = 1'b1; wt(HP); scl = 1'b1; wt(HP); sda_drv = 1'b0; wt(HP); scl = 1'b0; wt(2);
  endtask
  task automatic i2c_stop();
    sda_drv = 1'b0; wt(HP); scl = 1'b1; wt(HP); sda_drv = 1'b1; wt(HP);
  endtask
  task automatic bit_clk(input logic v, output logic s);
    sda_drv = v; wt(HP); scl = 1'b1; wt(HP/2); s = sda_line; wt(HP/2); scl = 1'b0; wt(2);
  endtask
  task automatic send_byte(input logic [7:0] b, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_clk(b[i], s);
    bit_clk(1'b1, s);
    ack = (s == 1'b0);
  endtask
  task automatic recv_byte(output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin bit_clk(1'b1, s); b[i] = s; end
    bit_clk(1'b1, s);  // master NACK
  endtask

  task automatic write_reg(input logic [7:0] a, input logic [7:0] d, output bit all_ack);
    bit k0, k1, k2;
    i2c_start(); send_byte({DEV, 1'b0}, k0); send_byte(a, k1); send_byte(d, k2); i2c_stop();
    all_ack = k0 & k1 & k2;
  endtask
  task automatic read_reg(input logic [7:0] a, output logic [7:0] d, output bit all_ack);
    bit k0, k1, k2;
    i2c_start(); send_byte({DEV, 1'b0}, k0); send_byte(a, k1);
    i2c_rstart(); send_byte({DEV, 1'b1}, k2); recv_byte(d); i2c_stop();
    all_ack = k0 & k1 & k2;
  endtask
  task automatic poll(output bit ack);
    i2c_start(); send_byte({DEV, 1'b0}, ack); i2c_stop();
  endtask

  task automatic t_reset();
    logic [7:0] d; bit k;
    chk(tap == NVI, "R1 recall after reset", tap, NVI);
    read_reg(8'h02, d, k);
    chk(k && d == 8'h00, "R3 ctrl reset read", d, 0);
    read_reg(8'h00, d, k);
    chk(k && d == NVI, "R3 nv copy read", d, NVI);
  endtask

  task automatic t_volatile();
    logic [7:0] d; bit k;
    write_reg(8'h02, 8'h01, k); chk(k, "R2 ctrl write acks", k, 1);
    write_reg(8'h00, 8'h33, k); chk(k, "R2 wiper write acks", k, 1);
    chk(tap == 8'h33, "R2 tap follows wiper", tap, 8'h33);
    poll(k); chk(k, "R8 no commit with ctrl nonzero", k, 1);
    read_reg(8'h00, d, k); chk(k && d == 8'h33, "R3 volatile read", d, 8'h33);
    read_reg(8'h02, d, k); chk(d == 8'h01, "R3 ctrl read", d, 1);
    write_reg(8'h02, 8'h00, k);
    read_reg(8'h00, d, k); chk(d == NVI, "R3 nv read not wiper", d, NVI);
    chk(tap == 8'h33, "R3 read leaves tap", tap, 8'h33);
  endtask

  task automatic t_commit();
    logic [7:0] d; bit k;
    write_reg(8'h00, 8'hC5, k); chk(k && tap == 8'hC5, "R2 wiper write", tap, 8'hC5);
    poll(k); chk(!k, "R5 nack while committing", k, 0);
    chk(tap == 8'hC5, "R5 wiper held", tap, 8'hC5);
    wt(400);
    poll(k); chk(k, "R5 ack after commit", k, 1);
    read_reg(8'h00, d, k); chk(d == 8'hC5, "R4 nv updated", d, 8'hC5);
  endtask

  task automatic t_wp();
    logic [7:0] d; bit k;
    wp = 1'b1; wt(4);
    write_reg(8'h00, 8'h11, k); chk(k, "R6 acks under wp", k, 1);
    chk(tap == 8'hC5, "R6 wiper unchanged", tap, 8'hC5);
    poll(k); chk(k, "R6 no commit under wp", k, 1);
    write_reg(8'h02, 8'h07, k);
    wp = 1'b0; wt(4);
    read_reg(8'h02, d, k); chk(d == 8'h00, "R6 ctrl unchanged", d, 0);
  endtask

  task automatic t_mismatch();
    bit k0, k1;
    i2c_start(); send_byte({7'h2D, 1'b0}, k0); send_byte(8'h00, k1); i2c_stop();
    chk(!k0, "R7 foreign id nack", k0, 0);
    chk(!k1, "R7 released after mismatch", k1, 0);
    chk(tap == 8'hC5, "R7 tap unchanged", tap, 8'hC5);
  endtask

  task automatic t_other_addr();
    logic [7:0] d; bit k;
    write_reg(8'h05, 8'h99, k); chk(k, "R2 other address acked", k, 1);
    read_reg(8'h05, d, k); chk(d == 8'h00, "R3 other address reads zero", d, 0);
    chk(tap == 8'hC5, "R2 other address no change", tap, 8'hC5);
  endtask

  task automatic t_recall();
    rst_n = 1'b0; wt(4);
    chk(tap == 8'h00, "R1 tap during reset", tap, 0);
    rst_n = 1'b1; wt(3);
    chk(tap == 8'hC5, "R1 recall committed value", tap, 8'hC5);
  endtask

  initial begin
    wt(5); rst_n = 1'b1; wt(5);
    t_reset();
    t_volatile();
    t_commit();
    t_wp();
    t_mismatch();
    t_other_addr();
    t_recall();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150_000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule